// File: doc/BRIEF.md
# Fixed-Priority Restart Interrupt Controller

This block arbitrates five interrupt sources for a small processor core: a non-maskable trap, three maskable restart levels (numbered 2, 1 and 0 from highest to lowest) and one general request. The core pulses a sample strobe on the next-to-last clock of each instruction. The controller decides in that cycle whether an interrupt is taken and which one. One clock later it presents an accept strobe and a restart vector. For the general request it raises a flag instead, which tells the bus sequencer to run an external acknowledge cycle and hold the program counter. Stacking the return address and running the service routine belong to the core.

The controller keeps a global interrupt-enable flag and a three-bit restart mask. Software-side commands from the core drive them: enable, disable, set-mask and read-mask. The sources have different sensitivities. The trap needs a rising edge and a level that is still high when it is sampled. Restart level 2 is caught by a rising-edge latch. Levels 1 and 0 and the general request are plain levels. All five inputs pass through a synchroniser before any decision is made.

Top module: `prio_intc`

## Requirements
- R1: After reset the enable flag is 0, all three mask bits are 1, no edge latch is pending and `accept_o` is 0.
- R2: A trap is taken whatever the enable flag and mask bits are, and its vector is 0x0024.
- R3: A set-mask command loads `setmask_data_i[2:0]` into the mask only when bit 3 is 1 (mask bit k covers restart level k). When bit 4 is 1 the command clears the level-2 edge latch. A restart level whose mask bit is 1 is not taken.
- R4: The enable command sets the enable flag and the disable command clears it. The flag is also cleared in the same cycle that any interrupt is accepted. Only the trap is taken while the flag is 0.
- R5: When several requests are taken together, the fixed order from highest to lowest is trap, level 2, level 1, level 0, general request. This order depends only on the pending requests, so a lower level can be taken again as soon as the enable flag is set.
- R6: Decisions are made only in a cycle with `sample_i` high. `accept_o`, `vec_o` and `gen_ack_o` are registered and change on the clock edge that ends that cycle.
- R7: A taken general request gives `accept_o`=1, `gen_ack_o`=1 and `vec_o`=0. It needs the enable flag.
- R8: Restart vectors are 0x003C for level 2, 0x0034 for level 1 and 0x002C for level 0. `gen_ack_o` is 0 for these and for the trap.
- R9: A rising edge on level 2 is latched even while that level is masked or interrupts are disabled. The latch holds until level 2 is taken or a set-mask clears it. Levels 1 and 0 stay requested for as long as their input is high.
- R10: A trap that stays high is taken once per rising edge. A trap pulse that has gone low before the sample cycle is not taken.
- R11: A read-mask command loads `status_o` one cycle later with {pending level 2, 1, 0 in bits [6:4]; enable flag in bit 3; mask in bits [2:0]}.
- R12: Each input goes through two synchroniser flops. A general request or level input that changes in one cycle is first seen by a sample strobe two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_i | input | 1 | Non-maskable trap request (asynchronous) |
| lvl_i | input | 3 | Restart level requests, bit 2 highest (asynchronous) |
| gen_req_i | input | 1 | General interrupt request (asynchronous) |
| sample_i | input | 1 | Core's instruction sampling point |
| ei_i | input | 1 | Enable-interrupts command |
| di_i | input | 1 | Disable-interrupts command |
| setmask_i | input | 1 | Set-mask command strobe |
| setmask_data_i | input | 5 | [2:0] mask, [3] mask write enable, [4] clear level-2 latch |
| rdmask_i | input | 1 | Read-mask command strobe |
| accept_o | output | 1 | Interrupt accepted this cycle |
| vec_o | output | 16 | Restart vector of the accepted source |
| gen_ack_o | output | 1 | Run an acknowledge cycle for the general request |
| status_o | output | 7 | Pending, enable and mask snapshot |

## Verification
A wrong enable flag or mask bit shows up at the next sample strobe. An interrupt is then taken or refused against the expected pattern, and the difference appears on `accept_o` one clock later. A stale or lost level-2 latch shows the same way on `vec_o`, and it also shows in the pending field of the next read-mask snapshot. Trap edge tracking is checked by holding the trap high over two sample strobes and by a pulse that ends before sampling, so a latch that fails to clear or a missing level check shows on the next strobe.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

    // Default geometry of the controller
    localparam int unsigned RST_LEVELS  = 3;   // maskable restart levels
    localparam int unsigned VEC_WIDTH   = 16;  // width of the vector output
    localparam int unsigned SYNC_DEPTH  = 2;   // synchroniser flops per input
    localparam int unsigned VEC_LOWEST  = 'h2C; // vector of restart level 0
    localparam int unsigned VEC_SPACING = 8;    // distance between level vectors

    // Vector of restart level idx; the trap sits one spacing below level 0
    function automatic int unsigned level_vector(input int unsigned idx,
                                                 input int unsigned base,
                                                 input int unsigned step);
        return base + step * idx;
    endfunction

    function automatic int unsigned trap_vector(input int unsigned base,
                                                input int unsigned step);
        return base - step;
    endfunction

endpackage

// File: rtl/prio_intc_sync.sv
module prio_intc_sync #(
    parameter int unsigned W      = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_q;
    logic [STAGES-1:0][W-1:0] stg_d;

    always_comb begin
        stg_d[0] = d;
        for (int s = 1; s < int'(STAGES); s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/prio_intc_edge.sv
module prio_intc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,     // synchronised input
    input  logic clr,     // service or software clear
    output logic pend     // latched rising edge
);
    typedef struct packed {
        logic prev;
        logic pend;
    } edge_st_t;

    edge_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        if (clr)             st_d.pend = 1'b0;
        if (lvl && !st_q.prev) st_d.pend = 1'b1;  // a new edge wins over a clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/prio_intc_resolve.sv
module prio_intc_resolve #(
    parameter int unsigned NSRC     = 5,
    parameter int unsigned AW       = 16,
    parameter int unsigned VBASE    = 'h2C,
    parameter int unsigned VSTEP    = 8
) (
    input  logic [NSRC-1:0] req,     // [NSRC-1] trap ... [0] general
    output logic [NSRC-1:0] grant,
    output logic            any,
    output logic [AW-1:0]   vec
);
    import prio_intc_pkg::*;

    logic higher;

    always_comb begin
        higher = 1'b0;
        grant  = '0;
        for (int i = int'(NSRC) - 1; i >= 0; i--) begin
            grant[i] = req[i] & ~higher;
            higher   = higher | req[i];
        end
    end

    always_comb begin
        vec = '0;
        for (int i = 1; i < int'(NSRC) - 1; i++) begin
            if (grant[i]) vec = AW'(level_vector(i - 1, VBASE, VSTEP));
        end
        if (grant[NSRC-1]) vec = AW'(trap_vector(VBASE, VSTEP));
    end

    assign any = |grant;
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
    parameter int unsigned NUM_RST = prio_intc_pkg::RST_LEVELS,
    parameter int unsigned ADDR_W  = prio_intc_pkg::VEC_WIDTH,
    parameter int unsigned SYNC_N  = prio_intc_pkg::SYNC_DEPTH,
    parameter int unsigned VBASE   = prio_intc_pkg::VEC_LOWEST,
    parameter int unsigned VSTEP   = prio_intc_pkg::VEC_SPACING
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trap_i,
    input  logic [NUM_RST-1:0]   lvl_i,
    input  logic                 gen_req_i,
    input  logic                 sample_i,
    input  logic                 ei_i,
    input  logic                 di_i,
    input  logic                 setmask_i,
    input  logic [NUM_RST+1:0]   setmask_data_i,
    input  logic                 rdmask_i,
    output logic                 accept_o,
    output logic [ADDR_W-1:0]    vec_o,
    output logic                 gen_ack_o,
    output logic [2*NUM_RST:0]   status_o
);
    localparam int unsigned NSRC   = NUM_RST + 2;
    localparam int unsigned TOP    = NSRC - 1;        // trap index
    localparam int unsigned L_EDGE = NSRC - 2;        // edge-latched level index
    localparam int unsigned MWE    = NUM_RST;         // mask write enable bit
    localparam int unsigned CLRB   = NUM_RST + 1;     // latch clear bit
    localparam int unsigned STW    = 2 * NUM_RST + 1;

    typedef struct packed {
        logic               ie;
        logic [NUM_RST-1:0] mask;
        logic               take;
        logic [ADDR_W-1:0]  vec;
        logic               ack;
        logic [STW-1:0]     stat;
    } ctl_t;

    ctl_t st_q, st_d;

    logic [NSRC-1:0]    sy;
    logic               trap_pend, edge_pend;
    logic [NUM_RST-1:0] lvl_pend;
    logic [NSRC-1:0]    req, grant;
    logic               any_grant;
    logic [ADDR_W-1:0]  res_vec;
    logic               edge_clr;

    // Synchronise every request input
    prio_intc_sync #(.W(NSRC), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({trap_i, lvl_i, gen_req_i}),
        .q     (sy)
    );

    // Trap: edge latch qualified by the present level
    prio_intc_edge u_trap_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sy[TOP]),
        .clr   (grant[TOP]),
        .pend  (trap_pend)
    );

    // Highest restart level: edge latch held until serviced or cleared
    assign edge_clr = grant[L_EDGE] | (setmask_i & setmask_data_i[CLRB]);

    prio_intc_edge u_lvl_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sy[L_EDGE]),
        .clr   (edge_clr),
        .pend  (edge_pend)
    );

    // Pending view of the restart levels
    generate
        for (genvar k = 0; k < int'(NUM_RST); k++) begin : g_lvl
            if (k == int'(NUM_RST) - 1) begin : g_edge
                assign lvl_pend[k] = edge_pend;
            end else begin : g_level
                assign lvl_pend[k] = sy[k+1];
            end
        end
    endgenerate

    // Qualified requests, only at the sampling point
    always_comb begin
        req           = '0;
        req[TOP]      = trap_pend & sy[TOP];
        req[TOP-1:1]  = lvl_pend & ~st_q.mask & {NUM_RST{st_q.ie}};
        req[0]        = sy[0] & st_q.ie;
        if (!sample_i) req = '0;
    end

    prio_intc_resolve #(.NSRC(NSRC), .AW(ADDR_W), .VBASE(VBASE), .VSTEP(VSTEP)) u_res (
        .req   (req),
        .grant (grant),
        .any   (any_grant),
        .vec   (res_vec)
    );

    always_comb begin
        st_d      = st_q;
        st_d.take = any_grant;
        st_d.vec  = res_vec;
        st_d.ack  = grant[0];
        if (ei_i)      st_d.ie = 1'b1;
        if (di_i)      st_d.ie = 1'b0;
        if (any_grant) st_d.ie = 1'b0;
        if (setmask_i && setmask_data_i[MWE]) st_d.mask = setmask_data_i[NUM_RST-1:0];
        if (rdmask_i)  st_d.stat = {lvl_pend, st_q.ie, st_q.mask};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept_o  = st_q.take;
    assign vec_o     = st_q.vec;
    assign gen_ack_o = st_q.ack;
    assign status_o  = st_q.stat;

    // Internal state exposed to the bound checker
    logic               ie_w;
    logic [NUM_RST-1:0] mask_w;
    assign ie_w   = st_q.ie;
    assign mask_w = st_q.mask;
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
    parameter int unsigned NUM_RST = 3,
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned VBASE   = 'h2C,
    parameter int unsigned VSTEP   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sample_i,
    input logic               setmask_i,
    input logic [NUM_RST+1:0] setmask_data_i,
    input logic               accept_o,
    input logic [ADDR_W-1:0]  vec_o,
    input logic               gen_ack_o,
    input logic               ie_w,
    input logic [NUM_RST-1:0] mask_w
);
    localparam logic [ADDR_W-1:0] TRAP_V = ADDR_W'(VBASE - VSTEP);
    localparam logic [ADDR_W-1:0] L0_V   = ADDR_W'(VBASE);
    localparam logic [ADDR_W-1:0] L1_V   = ADDR_W'(VBASE + VSTEP);
    localparam logic [ADDR_W-1:0] L2_V   = ADDR_W'(VBASE + 2 * VSTEP);

    assert_accept_after_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> $past(sample_i));

    assert_accept_clears_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> !ie_w);

    assert_ack_only_general_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gen_ack_o |-> (accept_o && vec_o == '0));

    assert_restart_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !gen_ack_o) |-> (vec_o == TRAP_V || vec_o == L0_V ||
                                      vec_o == L1_V || vec_o == L2_V));

    assert_disabled_only_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && $past(!ie_w)) |-> (vec_o == TRAP_V && !gen_ack_o));

    assert_mask_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(setmask_i && setmask_data_i[NUM_RST]) |-> (mask_w == $past(setmask_data_i[NUM_RST-1:0])));
endmodule

bind prio_intc prio_intc_chk #(
    .NUM_RST (NUM_RST),
    .ADDR_W  (ADDR_W),
    .VBASE   (VBASE),
    .VSTEP   (VSTEP)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sample_i       (sample_i),
    .setmask_i      (setmask_i),
    .setmask_data_i (setmask_data_i),
    .accept_o       (accept_o),
    .vec_o          (vec_o),
    .gen_ack_o      (gen_ack_o),
    .ie_w           (ie_w),
    .mask_w         (mask_w)
);

// File: tb/test_prio_intc.sv
module test_prio_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_i = 1'b0;
    logic [2:0]  lvl_i = '0;
    logic        gen_req_i = 1'b0;
    logic        sample_i = 1'b0;
    logic        ei_i = 1'b0;
    logic        di_i = 1'b0;
    logic        setmask_i = 1'b0;
    logic [4:0]  setmask_data_i = '0;
    logic        rdmask_i = 1'b0;
    logic        accept_o;
    logic [15:0] vec_o;
    logic        gen_ack_o;
    logic [6:0]  status_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic smp_d = 1'b0;

    logic        q_take[$];
    logic [15:0] q_vec[$];
    logic        q_ack[$];
    string       q_tag[$];

    always #10 clk = ~clk;   // 50 MHz

    prio_intc i_prio_intc (
        .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .lvl_i(lvl_i),
        .gen_req_i(gen_req_i), .sample_i(sample_i), .ei_i(ei_i), .di_i(di_i),
        .setmask_i(setmask_i), .setmask_data_i(setmask_data_i),
        .rdmask_i(rdmask_i), .accept_o(accept_o), .vec_o(vec_o),
        .gen_ack_o(gen_ack_o), .status_o(status_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: one sample strobe, expected outcome pushed to the scoreboard
    task automatic do_sample(input logic take, input logic [15:0] vec,
                             input logic ack, input string tag);
        sample_i = 1'b1;
        q_take.push_back(take);
        q_vec.push_back(vec);
        q_ack.push_back(ack);
        q_tag.push_back(tag);
        tick(1);
        sample_i = 1'b0;
    endtask

    task automatic cmd_ei();
        ei_i = 1'b1; tick(1); ei_i = 1'b0;
    endtask

    task automatic cmd_di();
        di_i = 1'b1; tick(1); di_i = 1'b0;
    endtask

    task automatic cmd_mask(input logic [4:0] d);
        setmask_i = 1'b1; setmask_data_i = d; tick(1);
        setmask_i = 1'b0; setmask_data_i = '0;
    endtask

    task automatic rd_status(input logic [6:0] exp, input string tag);
        rdmask_i = 1'b1; tick(1); rdmask_i = 1'b0;
        checks++;
        if (status_o !== exp) begin
            errors++;
            $display("FAIL %s: status actual %h expected %h", tag, status_o, exp);
        end
    endtask

    // Monitor: compare the outcome one clock after each strobe
    always @(posedge clk) smp_d <= sample_i;

    always @(negedge clk) begin
        if (smp_d && q_take.size() > 0) begin
            logic        et;
            logic [15:0] ev;
            logic        ea;
            string       tg;
            et = q_take.pop_front();
            ev = q_vec.pop_front();
            ea = q_ack.pop_front();
            tg = q_tag.pop_front();
            checks++;
            if (accept_o !== et || gen_ack_o !== ea || (et && vec_o !== ev)) begin
                errors++;
                $display("FAIL %s: accept/ack/vec actual %b/%b/%h expected %b/%b/%h",
                         tg, accept_o, gen_ack_o, vec_o, et, ea, ev);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        checks++;
        if (accept_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: accept actual %b expected 0", accept_o);
        end
        rd_status(7'b000_0_111, "R1 reset status");

        cmd_mask(5'b01000);
        rd_status(7'b000_0_000, "R3 mask write / R11");

        // General request while disabled, then enabled
        gen_req_i = 1'b1; tick(4);
        do_sample(1'b0, 16'h0, 1'b0, "R7 general blocked while disabled");
        cmd_ei();
        rd_status(7'b000_1_000, "R11 enable bit");
        do_sample(1'b1, 16'h0000, 1'b1, "R7 general accepted with ack");
        do_sample(1'b0, 16'h0, 1'b0, "R4 enable cleared by accept");
        gen_req_i = 1'b0; tick(4);

        // Synchroniser latency
        cmd_ei();
        gen_req_i = 1'b1;
        tick(1);
        do_sample(1'b0, 16'h0, 1'b0, "R12 one cycle after change not seen");
        do_sample(1'b1, 16'h0000, 1'b1, "R12 seen two cycles after change");
        gen_req_i = 1'b0; tick(4);

        // Disable command
        cmd_ei(); cmd_di();
        gen_req_i = 1'b1; tick(4);
        do_sample(1'b0, 16'h0, 1'b0, "R4 disable command blocks");

        // Priority among restart levels and general
        lvl_i = 3'b011; cmd_ei(); tick(4);
        do_sample(1'b1, 16'h0034, 1'b0, "R5 level1 over level0 and general");
        cmd_ei();
        do_sample(1'b1, 16'h0034, 1'b0, "R9 level1 held level taken again");
        lvl_i = 3'b001; tick(4); cmd_ei();
        do_sample(1'b1, 16'h002C, 1'b0, "R8 level0 vector");
        lvl_i = 3'b000; tick(4); cmd_ei();
        do_sample(1'b1, 16'h0000, 1'b1, "R5 general lowest");
        gen_req_i = 1'b0; tick(4);

        // Masked level falls through to general
        cmd_mask(5'b01010);
        lvl_i = 3'b010; gen_req_i = 1'b1; cmd_ei(); tick(4);
        do_sample(1'b1, 16'h0000, 1'b1, "R3 masked level1 skipped");
        lvl_i = 3'b000; gen_req_i = 1'b0; tick(4);

        // Edge latch on level 2 while masked
        cmd_mask(5'b01100);
        lvl_i = 3'b100; tick(4); lvl_i = 3'b000; tick(4);
        rd_status(7'b100_0_100, "R9 level2 edge latched while masked");
        cmd_ei();
        do_sample(1'b0, 16'h0, 1'b0, "R3 masked level2 not taken");
        cmd_mask(5'b01000);
        do_sample(1'b1, 16'h003C, 1'b0, "R8 level2 vector from latch");
        cmd_ei();
        do_sample(1'b0, 16'h0, 1'b0, "R9 latch cleared after service");
        cmd_di();

        // Software clear of the latch, mask untouched
        lvl_i = 3'b100; tick(4); lvl_i = 3'b000; tick(4);
        rd_status(7'b100_0_000, "R9 latch pending again");
        cmd_mask(5'b10000);
        rd_status(7'b000_0_000, "R3 clear bit empties latch, mask kept");

        // Trap regardless of enable and masks
        cmd_mask(5'b01111);
        trap_i = 1'b1; tick(4);
        do_sample(1'b1, 16'h0024, 1'b0, "R2 trap while disabled and masked");
        do_sample(1'b0, 16'h0, 1'b0, "R10 held trap not retaken");
        trap_i = 1'b0; tick(4);
        trap_i = 1'b1; tick(4); trap_i = 1'b0; tick(4);
        do_sample(1'b0, 16'h0, 1'b0, "R10 trap pulse gone before sample");

        // Trap over level 2, then level 2 still pending
        cmd_mask(5'b01000); cmd_ei();
        trap_i = 1'b1; lvl_i = 3'b100; tick(4);
        do_sample(1'b1, 16'h0024, 1'b0, "R5 trap over level2");
        cmd_ei();
        do_sample(1'b1, 16'h003C, 1'b0, "R5 level2 after trap");
        trap_i = 1'b0; lvl_i = 3'b000; tick(4);

        // Pending view of level inputs
        lvl_i = 3'b011; tick(4);
        rd_status(7'b011_0_000, "R11 level pending bits");
        lvl_i = 3'b000;

        tick(3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule